// File: doc/BRIEF.md
# Display Window Fetch Address Generator

This block generates the 32-bit word addresses that a display pipeline reads from the frame buffer to fill the visible window. A timing generator supplies a retrace strobe at the start of each field, a strobe at the start of each line, and a per-pixel valid strobe while the beam is inside the active window. On each pixel strobe the block decides, from the configured pixel depth, whether that pixel is the first to touch a new 32-bit word, and if so it issues a fetch for that word.

Each field starts at one of two base addresses, chosen by a field flag that is sampled at the retrace strobe. Within a row, words are fetched at consecutive addresses. After the last word of a row, the row base moves forward by the row width plus a modulo, less one. A modulo of 1 makes rows contiguous. A modulo of one extra line length lets each interlaced field read every other frame line. Vertical panning is done by rewriting the two bases, and all configuration takes effect only at the next retrace strobe.

Top module: `dwin_fetch_agen`

## Requirements
- R1: After reset `fetch_req` is 0. No fetch is issued before the first `frame_start` pulse after reset.
- R2: `cfg_win_size` holds the row width in words minus one in bits 9:0, the line count minus one in bits 19:10 and the modulo in bits 29:20. Every fully scanned row issues exactly (width) fetches, at consecutive word addresses starting at the row base.
- R3: `cfg_pix_fmt` bits 3:2 hold bytes per pixel minus one (0 = 8, 1 = 16, 2 = 24, 3 = 32 bits per pixel). A fetch is issued on the pixel that first touches a new 32-bit word of the row. At 32 bpp this is every pixel. At 16 bpp it is every second pixel, starting with the first. At 24 bpp it is pixels 0, 1 and 2 of each group of four. At 8 bpp it is every fourth pixel.
- R4: After the last word of a row, the next row base is the old base plus (width minus one) plus the modulo. With a modulo of 1, consecutive rows are contiguous in memory.
- R5: With a modulo of 1 plus the words per line, successive rows of a field start two line lengths apart, so each field skips the alternate lines.
- R6: Once (line count) rows have completed in a field, no further fetch is issued until the next `frame_start`.
- R7: At `frame_start` the row base is loaded from `cfg_base_long` when `field_short` is 0, and from `cfg_base_short` when it is 1.
- R8: Changes to `cfg_win_size`, `cfg_pix_fmt`, `cfg_base_long` or `cfg_base_short` between `frame_start` pulses have no effect on fetches until the next `frame_start`.
- R9: A fetch is issued only for a cycle with `pix_valid` high. `fetch_req` and `fetch_addr` appear one clock after that pixel strobe. A `line_start` pulse restarts the word position of the row. Pixels beyond the row width issue nothing.
- R10: A `pix_valid` that arrives in the same cycle as `frame_start` or `line_start` is ignored, and no fetch is issued in the cycle after a `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Vertical retrace strobe; loads configuration and field base |
| line_start | input | 1 | Start-of-line strobe |
| pix_valid | input | 1 | One pixel inside the active window this cycle |
| field_short | input | 1 | Field flag sampled at retrace: 0 long field, 1 short field |
| cfg_win_size | input | 32 | Packed modulo, line count minus one, row words minus one |
| cfg_base_long | input | ADDR_W | Word address of the long field's first row |
| cfg_base_short | input | ADDR_W | Word address of the short field's first row |
| cfg_pix_fmt | input | 4 | Bits 3:2 bytes per pixel minus one |
| fetch_req | output | 1 | A word fetch is requested this cycle |
| fetch_addr | output | ADDR_W | Word address of the fetch |

## Verification
Fields are run at each of the four pixel depths. This separates the word-pacing patterns: every pixel, alternate pixels, three of four, and one of four. A contiguous-row field with a modulo of 1 is compared against an interlaced short field with a line-skipping modulo, which exposes any error in the row advance arithmetic or the base selection. Extra lines past the line count, extra pixels past the row width, strobes that collide, and configuration rewritten in mid-field all produce runs where the expected queue must stay empty or keep the old values. This shows a limit or a shadow register being ignored.

// File: rtl/dwin_pkg.sv
// Package: shared field positions and the captured configuration type for
// the display window fetch address generator.
package dwin_pkg;

    localparam int FIELD_W   = 10;   // width of each window-size field
    localparam int ROW_LSB   = 0;    // row words minus one
    localparam int LINE_LSB  = 10;   // line count minus one
    localparam int MOD_LSB   = 20;   // row-to-row modulo
    localparam int DEPTH_LSB = 2;    // bytes-per-pixel-minus-one field in pix_fmt

    typedef struct packed {
        logic [FIELD_W-1:0] row_code;
        logic [FIELD_W-1:0] line_code;
        logic [FIELD_W-1:0] modulo;
        logic [2:0]         bytes_pp;  // 1..4
    } win_cfg_t;

endpackage

// File: rtl/dwin_cfg_shadow.sv
// dwin_cfg_shadow: captures the window size and pixel depth at each
// retrace strobe so the rest of the block sees constant settings for a
// whole field. Assumes frame_start is a one-cycle pulse.
module dwin_cfg_shadow
    import dwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_start,
    input  logic [31:0] win_size_in,
    input  logic [3:0]  pix_fmt_in,
    output win_cfg_t    cfg_q,
    output logic        armed_q
);

    // Capture decoded settings at retrace; mark the block armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            armed_q <= 1'b0;
        end else if (frame_start) begin
            cfg_q.row_code  <= win_size_in[ROW_LSB  +: FIELD_W];
            cfg_q.line_code <= win_size_in[LINE_LSB +: FIELD_W];
            cfg_q.modulo    <= win_size_in[MOD_LSB  +: FIELD_W];
            cfg_q.bytes_pp  <= {1'b0, pix_fmt_in[DEPTH_LSB +: 2]} + 3'd1;
            armed_q         <= 1'b1;
        end
    end

    // R8: settings hold between retrace strobes.
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(cfg_q));

endmodule

// File: rtl/dwin_word_pacer.sv
// dwin_word_pacer: follows the byte position along the current row and
// flags the pixel that first touches a new 32-bit word. Assumes a pixel
// is at most four bytes, so one pixel opens at most one new word.
module dwin_word_pacer #(
    parameter int FIELD_W = 10,
    localparam int WORD_W = FIELD_W + 1,
    localparam int BYTE_W = WORD_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               line_start,
    input  logic               pix_valid,
    input  logic               enable,
    input  logic [FIELD_W-1:0] row_code,
    input  logic [2:0]         bytes_pp,
    output logic               issue,
    output logic [WORD_W-1:0]  word_idx,
    output logic               last_word
);

    logic [BYTE_W-1:0] byte_pos;
    logic [WORD_W-1:0] words_done;
    logic [WORD_W-1:0] row_words;
    logic [BYTE_W:0]   need_bytes;
    logic [WORD_W:0]   need_words;
    logic              words_full;
    logic              pix_ok;

    // Decode the word demand of the current pixel.
    always_comb begin
        row_words  = {1'b0, row_code} + WORD_W'(1);
        need_bytes = {1'b0, byte_pos} + (BYTE_W+1)'(bytes_pp) + (BYTE_W+1)'(3);
        need_words = need_bytes[BYTE_W:2];
        words_full = (words_done == row_words);
        pix_ok     = pix_valid && !frame_start && !line_start;
        issue      = pix_ok && enable && !words_full &&
                     (need_words > {1'b0, words_done});
        word_idx   = words_done;
        last_word  = (words_done == {1'b0, row_code});
    end

    // Advance byte and word positions; restart at line or field start.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start || line_start) begin
            byte_pos   <= '0;
            words_done <= '0;
        end else if (pix_ok && !words_full) begin
            byte_pos <= byte_pos + BYTE_W'(bytes_pp);
            if (issue) begin
                words_done <= words_done + WORD_W'(1);
            end
        end
    end

    // R3: a pixel never opens more than one new word.
    p_single_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (need_words == ({1'b0, words_done} + (WORD_W+1)'(1))));

    // R2: the word count of a row never passes the row width.
    p_words_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        words_done <= row_words);

endmodule

// File: rtl/dwin_row_walker.sv
// dwin_row_walker: holds the row base and the completed-line count, selects
// the field base at retrace, advances by width plus modulo after each row,
// and registers the outgoing fetch. Assumes bases are word addresses.
module dwin_row_walker #(
    parameter int ADDR_W  = 24,
    parameter int FIELD_W = 10,
    localparam int WORD_W = FIELD_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               field_short,
    input  logic [ADDR_W-1:0]  base_long,
    input  logic [ADDR_W-1:0]  base_short,
    input  logic               issue,
    input  logic [WORD_W-1:0]  word_idx,
    input  logic               last_word,
    input  logic [FIELD_W-1:0] row_code,
    input  logic [FIELD_W-1:0] line_code,
    input  logic [FIELD_W-1:0] modulo,
    output logic               lines_left,
    output logic               fetch_req,
    output logic [ADDR_W-1:0]  fetch_addr
);

    logic [ADDR_W-1:0] row_base;
    logic [WORD_W-1:0] line_idx;

    // Fields remain while the completed-line count is within the limit.
    always_comb begin
        lines_left = (line_idx <= {1'b0, line_code});
    end

    // Load the field base at retrace; step to the next row after its last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_base <= '0;
            line_idx <= '0;
        end else if (frame_start) begin
            row_base <= field_short ? base_short : base_long;
            line_idx <= '0;
        end else if (issue && last_word) begin
            row_base <= row_base + ADDR_W'(row_code) + ADDR_W'(modulo);
            line_idx <= line_idx + WORD_W'(1);
        end
    end

    // Register the fetch strobe and its word address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_req  <= 1'b0;
            fetch_addr <= '0;
        end else begin
            fetch_req  <= issue;
            fetch_addr <= row_base + ADDR_W'(word_idx);
        end
    end

    // R4: the row base only moves at retrace or after a row's last word.
    p_base_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !(issue && last_word)) |=> $stable(row_base));

    // R6: no word is issued once the field's lines are used up.
    p_line_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lines_left |-> !issue);

    // R10: the cycle after retrace carries no fetch.
    p_retrace_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !fetch_req);

endmodule

// File: rtl/dwin_fetch_agen.sv
// dwin_fetch_agen: top of the display window fetch address generator.
// Joins the configuration shadow, the per-pixel word pacer and the row
// walker. Assumes strobes come from one timing generator on clk.
module dwin_fetch_agen
    import dwin_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              pix_valid,
    input  logic              field_short,
    input  logic [31:0]       cfg_win_size,
    input  logic [ADDR_W-1:0] cfg_base_long,
    input  logic [ADDR_W-1:0] cfg_base_short,
    input  logic [3:0]        cfg_pix_fmt,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr
);

    localparam int WORD_W = FIELD_W + 1;

    win_cfg_t          cfg;
    logic              armed;
    logic              lines_left;
    logic              pace_en;
    logic              issue;
    logic [WORD_W-1:0] word_idx;
    logic              last_word;

    // Issue only once armed and while the field still has lines.
    always_comb begin
        pace_en = armed && lines_left;
    end

    dwin_cfg_shadow u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .win_size_in (cfg_win_size),
        .pix_fmt_in  (cfg_pix_fmt),
        .cfg_q       (cfg),
        .armed_q     (armed)
    );

    dwin_word_pacer #(.FIELD_W(FIELD_W)) u_pacer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_start  (line_start),
        .pix_valid   (pix_valid),
        .enable      (pace_en),
        .row_code    (cfg.row_code),
        .bytes_pp    (cfg.bytes_pp),
        .issue       (issue),
        .word_idx    (word_idx),
        .last_word   (last_word)
    );

    dwin_row_walker #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .field_short (field_short),
        .base_long   (cfg_base_long),
        .base_short  (cfg_base_short),
        .issue       (issue),
        .word_idx    (word_idx),
        .last_word   (last_word),
        .row_code    (cfg.row_code),
        .line_code   (cfg.line_code),
        .modulo      (cfg.modulo),
        .lines_left  (lines_left),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr)
    );

    // R9: every fetch follows a pixel strobe by one cycle.
    p_req_on_pixel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> $past(pix_valid));

    // R1: nothing is fetched until the first retrace has armed the block.
    p_quiet_until_armed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !issue);

endmodule

// File: tb/dwin_fetch_agen_test.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected word addresses, a monitor
// pops and compares them as fetches come out.
module dwin_fetch_agen_test;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          line_start = 1'b0;
    logic          pix_valid = 1'b0;
    logic          field_short = 1'b0;
    logic [31:0]   cfg_win_size = '0;
    logic [AW-1:0] cfg_base_long = '0;
    logic [AW-1:0] cfg_base_short = '0;
    logic [3:0]    cfg_pix_fmt = '0;
    logic          fetch_req;
    logic [AW-1:0] fetch_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    // model state
    int  m_w, m_l, m_mod, m_b;
    int  m_base, m_line, m_words, m_bytes;
    bit  m_armed = 1'b0;

    dwin_fetch_agen #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_start(line_start), .pix_valid(pix_valid),
        .field_short(field_short), .cfg_win_size(cfg_win_size),
        .cfg_base_long(cfg_base_long), .cfg_base_short(cfg_base_short),
        .cfg_pix_fmt(cfg_pix_fmt), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr)
    );

    always #4 clk = ~clk;

    // Monitor: compare every fetch against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && fetch_req && !finished) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected fetch: actual addr=%h expected none", fetch_addr);
            end else begin
                logic [AW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (fetch_addr !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual addr=%h expected %h", t, fetch_addr, e);
                end
            end
        end
    end

    function automatic logic [31:0] pack_win(int w, int l, int m);
        logic [31:0] v;
        v = '0;
        v[9:0]   = 10'(w - 1);
        v[19:10] = 10'(l - 1);
        v[29:20] = 10'(m);
        return v;
    endfunction

    task automatic step(input logic fs, input logic ls, input logic pv);
        frame_start = fs;
        line_start  = ls;
        pix_valid   = pv;
        @(posedge clk);
        #1;
        frame_start = 1'b0;
        line_start  = 1'b0;
        pix_valid   = 1'b0;
    endtask

    task automatic model_frame();
        m_w     = int'(cfg_win_size[9:0]) + 1;
        m_l     = int'(cfg_win_size[19:10]) + 1;
        m_mod   = int'(cfg_win_size[29:20]);
        m_b     = int'(cfg_pix_fmt[3:2]) + 1;
        m_base  = field_short ? int'(cfg_base_short) : int'(cfg_base_long);
        m_line  = 0;
        m_words = 0;
        m_bytes = 0;
        m_armed = 1'b1;
    endtask

    task automatic frame(input logic fld);
        field_short = fld;
        #0;
        model_frame();
        step(1'b1, 1'b0, 1'b0);
    endtask

    task automatic model_pixel(input string tag);
        int need;
        if (m_armed && m_line < m_l && m_words < m_w) begin
            need = (m_bytes + m_b + 3) / 4;
            if (need > m_words) begin
                exp_q.push_back(AW'(m_base + m_words));
                tag_q.push_back(tag);
                if (m_words == m_w - 1) begin
                    m_base = m_base + (m_w - 1) + m_mod;
                    m_line++;
                end
                m_words++;
            end
            m_bytes += m_b;
        end
    endtask

    task automatic line(input int npix, input string tag);
        m_words = 0;
        m_bytes = 0;
        step(1'b0, 1'b1, 1'b0);
        for (int k = 0; k < npix; k++) begin
            model_pixel(tag);
            step(1'b0, 1'b0, 1'b1);
        end
        step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic drain_check(input string tag);
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s: actual %0d fetches missing, expected 0 pending", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    // Watchdog: an expired run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        n_checks++;
        if (fetch_req !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: actual fetch_req=%b expected 0", fetch_req);
        end
        rst_n = 1'b1;

        // R1: pixels before any retrace issue nothing
        cfg_win_size = pack_win(4, 2, 1);
        cfg_pix_fmt  = 4'b1100;
        line(4, "R1 unarmed");
        drain_check("R1 unarmed");

        // R2 R4 R6 R9: 32 bpp, contiguous rows, extra line and extra pixels
        cfg_win_size  = pack_win(4, 3, 1);
        cfg_pix_fmt   = 4'b1100;
        cfg_base_long = 24'h000100;
        frame(1'b0);
        line(6, "R2 R9 32bpp row");
        line(4, "R4 contiguous");
        line(5, "R4 row3");
        line(4, "R6 past limit");
        drain_check("R6 line limit");

        // R3: 16 bpp every second pixel
        cfg_win_size  = pack_win(3, 2, 1);
        cfg_pix_fmt   = 4'b0100;
        cfg_base_long = 24'h002000;
        frame(1'b0);
        line(6, "R3 16bpp");
        line(7, "R3 16bpp row2");
        drain_check("R3 16bpp");

        // R3 R5 R7: 24 bpp interlaced short field, modulo skips a line
        cfg_win_size   = pack_win(3, 3, 1 + 3);
        cfg_pix_fmt    = 4'b1000;
        cfg_base_long  = 24'h004000;
        cfg_base_short = 24'h004003;
        frame(1'b1);
        line(4, "R3 R7 24bpp short");
        line(4, "R5 skip line");
        line(4, "R5 skip line2");
        drain_check("R5 interlace");

        // R7: long field of the same frame
        frame(1'b0);
        line(4, "R7 long field");
        drain_check("R7 long field");

        // R3: 8 bpp every fourth pixel
        cfg_win_size  = pack_win(2, 2, 5);
        cfg_pix_fmt   = 4'b0000;
        cfg_base_long = 24'hFFFFFE;
        frame(1'b0);
        line(8, "R3 8bpp");
        line(8, "R4 8bpp wrap");
        drain_check("R3 8bpp");

        // R8: mid-field rewrite has no effect until the next retrace
        cfg_win_size  = pack_win(2, 2, 1);
        cfg_pix_fmt   = 4'b1100;
        cfg_base_long = 24'h010000;
        frame(1'b0);
        cfg_win_size  = pack_win(4, 4, 9);
        cfg_pix_fmt   = 4'b0000;
        cfg_base_long = 24'h020000;
        line(2, "R8 old cfg");
        line(4, "R8 old cfg row2");
        drain_check("R8 shadow");
        frame(1'b0);
        line(16, "R8 new cfg");
        drain_check("R8 new cfg");

        // R10: strobe collisions drop the pixel
        cfg_win_size  = pack_win(2, 1, 1);
        cfg_pix_fmt   = 4'b1100;
        cfg_base_long = 24'h030000;
        field_short = 1'b0;
        #0;
        model_frame();
        step(1'b1, 1'b0, 1'b1);   // pixel with retrace: ignored
        step(1'b0, 1'b0, 1'b0);
        n_checks++;
        if (fetch_req !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 retrace collide: actual fetch_req=%b expected 0", fetch_req);
        end
        m_words = 0;
        m_bytes = 0;
        step(1'b0, 1'b1, 1'b1);   // pixel with line start: ignored
        model_pixel("R10 after collide");
        step(1'b0, 1'b0, 1'b1);
        model_pixel("R10 after collide");
        step(1'b0, 1'b0, 1'b1);
        drain_check("R10 collide");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule